// File: doc/BRIEF.md
# Configuration Transaction Command Controller

This block lets a processor run one read or one write at a time against a remote configuration function on a board's configuration network, such as a clock generator, a supply regulator or a temperature sensor. Software sees three 32-bit registers: a data word, a command word and a status word. The command word names the target through five packed fields: a controller number, a function code, a site, a board position and a device index. It also carries a direction bit and a start bit. Writing the command word with the start bit set launches the transaction on a simple downstream request port. The start bit then reads back as 1 until the transaction ends, so it serves as the busy flag.

The normal software sequence has three steps. Software loads the data word, then writes zero to the status word, then writes the command. It then polls until the status word is non-zero. COMPLETE and ERROR are separate sticky bits. Returned read data lands in the data word only when the transaction completes. If the remote side never answers, an internal cycle counter ends the transaction with ERROR after `TIMEOUT_CYC` cycles.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset, the data, command and status words all read 0 and `dn_req` is low.
- R2: The data word is at byte offset 0x0A0, the command word at 0x0A4 and the status word at 0x0A8. Any other offset reads 0. Command bits 19:18 and status bits 31:2 always read 0, whatever was written to them.
- R3: A command write with bit 31 set, made while idle, makes bit 31 read back 1 from the next cycle on. It also drives `dn_req` high for exactly one cycle, the cycle after the write.
- R4: The target outputs follow the stored command word: `dn_ctl` = bits 29:26, `dn_func` = bits 25:20, `dn_site` = bits 17:16, `dn_pos` = bits 15:12, `dn_dev` = bits 11:0, and `dn_write` = bit 30 (1 = write, 0 = read).
- R5: `dn_wdata` presents the data word throughout the transaction.
- R6: `dn_done` during a transaction clears command bit 31 and sets status bit 0 (COMPLETE) on the next cycle.
- R7: `dn_err` during a transaction clears bit 31 and sets status bit 1 (ERROR). Both bits are set when both responses arrive together. A response without error leaves bit 1 at 0.
- R8: On a read whose response includes `dn_done`, the data word takes `dn_rdata`. A read that ends in error only, or any write, leaves the data word unchanged.
- R9: While bit 31 is 1, writes to the command word and to the data word have no effect.
- R10: Status bits stay set until software writes the status word. Such a write loads its bits 1:0.
- R11: With no response, bit 31 clears and ERROR sets after exactly `TIMEOUT_CYC` busy cycles, with COMPLETE left at 0.
- R12: `dn_done` and `dn_err` have no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| dn_req | output | 1 | One-cycle transaction request |
| dn_write | output | 1 | Direction: 1 write, 0 read |
| dn_ctl | output | 4 | Controller number |
| dn_func | output | 6 | Function code |
| dn_site | output | 2 | Site |
| dn_pos | output | 4 | Board position |
| dn_dev | output | 12 | Device index |
| dn_wdata | output | 32 | Write data to the target |
| dn_done | input | 1 | Target reports completion |
| dn_err | input | 1 | Target reports failure |
| dn_rdata | input | 32 | Read data from the target |

## Verification
The bench goes after the corner cases that are easy to get wrong.

- **Writes while busy.** A design that let such writes through would corrupt the in-flight write data, or would launch a second request.
- **Read that fails.** A design that captured `dn_rdata` on error would overwrite the data word with garbage.
- **Simultaneous completion and error.** A priority encoder here would lose one of the two status bits.
- **Response while idle.** A design that did not gate the response would set status without any transaction.
- **Timeout.** An off-by-one in the counter would move the clearing of the busy bit by one cycle. A per-cycle reference model exposes that directly.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
  localparam logic [11:0] OFF_DATA = 12'h0A0;
  localparam logic [11:0] OFF_CMD  = 12'h0A4;
  localparam logic [11:0] OFF_STAT = 12'h0A8;

  typedef struct packed {
    logic       go;
    logic       wr;
    logic [3:0] ctl;
    logic [5:0] fn;
    logic [1:0] rsv;
    logic [1:0] site;
    logic [3:0] pos;
    logic [11:0] dev;
  } cmd_t;

  function automatic cmd_t cmd_clean(input logic [31:0] w);
    cmd_t c;
    c = cmd_t'(w);
    c.rsv = 2'b00;
    return c;
  endfunction

  function automatic logic [1:0] stat_merge(input logic [1:0] cur,
                                            input logic ok, input logic bad);
    return cur | {bad, ok};
  endfunction
endpackage

// File: rtl/cfgt_timer.sv
module cfgt_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic busy,
  input  logic resp_any,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expire = busy && !resp_any && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (launch)            cnt_q <= '0;
    else if (busy && !resp_any) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfgt_regs.sv
module cfgt_regs
  import cfgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_data,
  input  logic        wr_cmd,
  input  logic        wr_stat,
  input  logic [31:0] wdata,
  input  logic        launch,
  input  logic        resp_ok,
  input  logic        resp_bad,
  input  logic        tmo,
  input  logic [31:0] rdata_in,
  output logic [31:0] data_q,
  output cmd_t        cmd_q,
  output logic [1:0]  stat_q,
  output logic        req_q
);
  logic       busy;
  logic       finish;
  logic [1:0] stat_base;

  assign busy      = cmd_q.go;
  assign finish    = resp_ok || resp_bad || tmo;
  assign stat_base = wr_stat ? wdata[1:0] : stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q  <= launch;
      stat_q <= stat_merge(stat_base, resp_ok, resp_bad || tmo);
      if (finish)              cmd_q.go <= 1'b0;
      else if (wr_cmd && !busy) cmd_q   <= cmd_clean(wdata);
      if (resp_ok && !cmd_q.wr)  data_q <= rdata_in;
      else if (wr_data && !busy) data_q <= wdata;
    end
  end
endmodule

// File: rtl/cfgt_rdmux.sv
module cfgt_rdmux
  import cfgt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       data_q,
  input  cmd_t              cmd_q,
  input  logic [1:0]        stat_q,
  output logic [31:0]       rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_DATA))      rdata = data_q;
    else if (addr == ADDR_W'(OFF_CMD))  rdata = cmd_q;
    else if (addr == ADDR_W'(OFF_STAT)) rdata = {30'd0, stat_q};
  end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfgt_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dn_req,
  output logic              dn_write,
  output logic [3:0]        dn_ctl,
  output logic [5:0]        dn_func,
  output logic [1:0]        dn_site,
  output logic [3:0]        dn_pos,
  output logic [11:0]       dn_dev,
  output logic [31:0]       dn_wdata,
  input  logic              dn_done,
  input  logic              dn_err,
  input  logic [31:0]       dn_rdata
);
  cmd_t        cmd_q;
  logic [31:0] data_q;
  logic [1:0]  stat_q;
  logic        busy, launch, resp_ok, resp_bad, tmo, finish;
  logic        wr_data_hit, wr_cmd_hit, wr_stat_hit;

  assign wr_data_hit = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign wr_cmd_hit  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign wr_stat_hit = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));

  assign busy     = cmd_q.go;
  assign launch   = wr_cmd_hit && !busy && bus_wdata[31];
  assign resp_ok  = busy && dn_done;
  assign resp_bad = busy && dn_err;
  assign finish   = resp_ok || resp_bad || tmo;

  cfgt_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
    .resp_any(resp_ok || resp_bad), .expire(tmo)
  );

  cfgt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data_hit), .wr_cmd(wr_cmd_hit),
    .wr_stat(wr_stat_hit), .wdata(bus_wdata), .launch(launch),
    .resp_ok(resp_ok), .resp_bad(resp_bad), .tmo(tmo), .rdata_in(dn_rdata),
    .data_q(data_q), .cmd_q(cmd_q), .stat_q(stat_q), .req_q(dn_req)
  );

  cfgt_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr(bus_addr), .data_q(data_q), .cmd_q(cmd_q), .stat_q(stat_q),
    .rdata(bus_rdata)
  );

  assign dn_write = cmd_q.wr;
  assign dn_ctl   = cmd_q.ctl;
  assign dn_func  = cmd_q.fn;
  assign dn_site  = cmd_q.site;
  assign dn_pos   = cmd_q.pos;
  assign dn_dev   = cmd_q.dev;
  assign dn_wdata = data_q;
endmodule

// File: rtl/cfgt_chk.sv
module cfgt_chk #(
  parameter int LIMIT = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        launch,
  input logic        finish,
  input logic        resp_ok,
  input logic        resp_bad,
  input logic        tmo,
  input logic        wr_stat,
  input logic        req,
  input logic [1:0]  stat,
  input logic [31:0] cmd,
  input logic [31:0] data
);
  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= 0;
    else if (launch) run_q <= 0;
    else if (busy)   run_q <= run_q + 1;
  end

  assert_launch_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (req && busy));
  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);
  assert_finish_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ok |=> stat[0]);
  assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_bad || tmo) |=> stat[1]);
  assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(cmd));
  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(data));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_stat) |=> $stable(stat));
  assert_tmo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < LIMIT));
endmodule

bind cfg_txn_ctrl cfgt_chk #(.LIMIT(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .launch(launch), .finish(finish),
  .resp_ok(resp_ok), .resp_bad(resp_bad), .tmo(tmo), .wr_stat(wr_stat_hit),
  .req(dn_req), .stat(stat_q), .cmd(cmd_q), .data(data_q)
);

// File: tb/cfg_txn_ctrl_test.sv
module cfg_txn_ctrl_test;
  localparam int LIM = 40;
  localparam logic [11:0] A_DATA = 12'h0A0, A_CMD = 12'h0A4, A_STAT = 12'h0A8;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dn_req, dn_write, dn_done = 0, dn_err = 0;
  logic [3:0] dn_ctl, dn_pos;
  logic [5:0] dn_func;
  logic [1:0] dn_site;
  logic [11:0] dn_dev;
  logic [31:0] dn_wdata, dn_rdata = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_txn_ctrl #(.ADDR_W(12), .TIMEOUT_CYC(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dn_req(dn_req),
    .dn_write(dn_write), .dn_ctl(dn_ctl), .dn_func(dn_func),
    .dn_site(dn_site), .dn_pos(dn_pos), .dn_dev(dn_dev),
    .dn_wdata(dn_wdata), .dn_done(dn_done), .dn_err(dn_err),
    .dn_rdata(dn_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model, updated behaviourally from the requirements.
  logic [31:0] m_data, m_cmd;
  logic [1:0]  m_stat;
  logic        m_req;
  int          m_cnt;
  always @(posedge clk) begin
    logic idle_bsy, ok, bad, to;
    logic [31:0] nd, nc;
    logic [1:0] ns;
    if (!rst_n) begin
      m_data = 0; m_cmd = 0; m_stat = 0; m_req = 0; m_cnt = 0;
    end else begin
      idle_bsy = m_cmd[31];
      ok  = idle_bsy && dn_done;
      bad = idle_bsy && dn_err;
      to  = idle_bsy && !dn_done && !dn_err && (m_cnt == LIM - 1);
      nd = m_data; nc = m_cmd; ns = m_stat;
      if (bus_wr && bus_addr == A_STAT) ns = bus_wdata[1:0];
      if (ok) ns[0] = 1'b1;
      if (bad || to) ns[1] = 1'b1;
      if (ok || bad || to) nc[31] = 1'b0;
      else if (bus_wr && bus_addr == A_CMD && !idle_bsy) nc = bus_wdata & 32'hFFF3_FFFF;
      if (ok && !m_cmd[30]) nd = dn_rdata;
      else if (bus_wr && bus_addr == A_DATA && !idle_bsy) nd = bus_wdata;
      m_req = bus_wr && bus_addr == A_CMD && !idle_bsy && bus_wdata[31];
      if (m_req) m_cnt = 0; else if (idle_bsy) m_cnt++;
      m_data = nd; m_cmd = nc; m_stat = ns;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    logic [31:0] er;
    er = (bus_addr == A_DATA) ? m_data : (bus_addr == A_CMD) ? m_cmd :
         (bus_addr == A_STAT) ? {30'd0, m_stat} : 32'd0;
    check("R2 model rdata", bus_rdata, er);
    check("R3 model req", {31'd0, dn_req}, {31'd0, m_req});
    check("R4 model fields", {dn_write, dn_ctl, dn_func, dn_site, dn_pos, dn_dev},
          {m_cmd[30:20], m_cmd[17:0]});
    check("R5 model wdata", dn_wdata, m_data);
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic respond(input logic ok, input logic bad, input logic [31:0] rv);
    @(posedge clk); #1;
    dn_done = ok; dn_err = bad; dn_rdata = rv;
    @(posedge clk); #1;
    dn_done = 0; dn_err = 0;
  endtask

  localparam logic [31:0] CMDW = {1'b1, 1'b1, 4'd5, 6'h2A, 2'b11, 2'd2, 4'd9, 12'hABC};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(A_DATA, 0, "R1 data reset");
    rd(A_CMD, 0, "R1 cmd reset");
    rd(A_STAT, 0, "R1 stat reset");
    check("R1 req reset", {31'd0, dn_req}, 0);
    rd(12'h0AC, 0, "R2 unmapped offset");

    // write transaction
    wr(A_DATA, 32'h1234_5678);
    wr(A_STAT, 0);
    wr(A_CMD, CMDW);
    @(negedge clk);
    check("R3 req pulse", {31'd0, dn_req}, 1);
    check("R4 fields", {dn_write, dn_ctl, dn_func, dn_site, dn_pos, dn_dev},
          {1'b1, 4'd5, 6'h2A, 2'd2, 4'd9, 12'hABC});
    check("R5 wdata", dn_wdata, 32'h1234_5678);
    rd(A_CMD, CMDW & 32'hFFF3_FFFF, "R2 R3 cmd readback");
    check("R3 req single", {31'd0, dn_req}, 0);
    wr(A_DATA, 32'hFFFF_0000);
    wr(A_CMD, 32'h8000_0001);
    rd(A_DATA, 32'h1234_5678, "R9 data held");
    rd(A_CMD, CMDW & 32'hFFF3_FFFF, "R9 cmd held");
    respond(1, 0, 32'h5555_5555);
    rd(A_CMD, (CMDW & 32'hFFF3_FFFF) & 32'h7FFF_FFFF, "R6 go cleared");
    rd(A_STAT, 1, "R6 complete");
    rd(A_DATA, 32'h1234_5678, "R8 write keeps data");
    repeat (3) @(posedge clk);
    rd(A_STAT, 1, "R10 sticky");
    respond(1, 1, 0);
    rd(A_STAT, 1, "R12 idle response");
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 3, "R2 R10 stat load");
    wr(A_STAT, 0);
    rd(A_STAT, 0, "R10 clear");

    // read transaction, success
    wr(A_DATA, 0);
    wr(A_CMD, 32'h8000_0042);
    repeat (2) @(posedge clk);
    respond(1, 0, 32'hCAFE_F00D);
    rd(A_DATA, 32'hCAFE_F00D, "R8 read capture");
    rd(A_STAT, 1, "R7 no error bit");

    // read ending in error only
    wr(A_STAT, 0);
    wr(A_DATA, 32'h11);
    wr(A_CMD, 32'h8000_0043);
    respond(0, 1, 32'h999);
    rd(A_STAT, 2, "R7 error only");
    rd(A_DATA, 32'h11, "R8 error keeps data");

    // both at once
    wr(A_STAT, 0);
    wr(A_CMD, 32'h8000_0044);
    respond(1, 1, 32'h77);
    rd(A_STAT, 3, "R7 both bits");

    // timeout
    wr(A_STAT, 0);
    wr(A_CMD, 32'h8000_0045);
    repeat (LIM - 3) @(posedge clk);
    rd(A_CMD, 32'h8000_0045, "R11 still busy");
    repeat (4) @(posedge clk);
    rd(A_CMD, 32'h0000_0045, "R11 go cleared");
    rd(A_STAT, 2, "R11 error only");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule